// File: doc/BRIEF.md
# Write-Through Line Cache

A 256-byte direct-mapped data cache placed between a 32-bit requester and a slower word-wide memory. It holds sixteen lines, and each line holds four 32-bit words. Every byte address is split into a tag, a line index, a word select and a byte select. A read that hits returns its word on the next cycle. A read that misses fetches the whole line with one burst request and returns the word only after the line is in place. Every write is passed to memory. A write also updates the cache. On a hit the bytes are merged into the cached word. On a miss the memory write is followed by a refill of the line, so the line then holds the new bytes.

Both sides use valid/ready handshakes. A request transfers on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until the response is presented, so the requester is stalled for the whole access. `rsp_valid` is a one-cycle pulse with no back-pressure, and the requester must take it. Toward memory, `mem_req_valid` and every request field are held unchanged until `mem_req_ready` is seen. Refill beats arrive on `mem_rsp_valid` and cannot be stalled.

Top module: `wt_line_cache`

## Requirements
- R1: After reset every line is invalid, so the first read of any address is a miss and issues a burst.
- R2: Address bits [1:0] select the byte, [3:2] the word, [7:4] the line and [31:8] the tag. A hit needs the line's valid bit set and its stored tag equal to bits [31:8].
- R3: A read miss issues exactly one memory request with `mem_req_write`=0 at the line-aligned address (bits [3:0] zero). It then takes four beats on `mem_rsp_valid`, which fill words 0, 1, 2, 3 in that order. Beats may have idle cycles between them.
- R4: After a read miss, `rsp_valid` pulses the cycle after the fourth beat and carries the requested word. The line is then valid, and reads of any of its words hit.
- R5: A read hit asserts `rsp_valid` with the cached word in the cycle after acceptance and makes no memory request.
- R6: Every write issues one memory request with `mem_req_write`=1 and the requester's address, data and byte enables unchanged.
- R7: A write hit merges the bytes whose `req_be` bit is set (bit n covers data bits [8n+7:8n]) into the cached word. It responds the cycle after memory accepts the write.
- R8: A write miss writes memory first and then refills the line by burst. It responds after the fourth beat, and the line then hits and holds the written bytes.
- R9: `req_ready` is low from acceptance until the response cycle. A memory request that is not yet accepted keeps its valid, address and direction stable.
- R10: Beats on `mem_rsp_valid` outside a refill are ignored. They produce no response and change no cached data.
- R11: Two addresses with the same line index and different tags evict each other, so alternating reads both miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Requester offers an access |
| req_ready | output | 1 | Cache can accept an access (low = stall) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Write byte enables |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read word (meaningful for reads) |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = single word write, 0 = four-beat burst read |
| mem_req_addr | output | 32 | Memory byte address |
| mem_req_wdata | output | 32 | Memory write data |
| mem_req_be | output | 4 | Memory write byte enables |
| mem_rsp_valid | input | 1 | Refill beat present |
| mem_rsp_data | input | 32 | Refill beat data |

## Verification
When the requested word is the last one in its line, three things happen in the cycle of the fourth refill beat. The beat is written into the array, the new tag and valid bit are set, and the response word is captured. The bench reads word 3 of a cold line to provoke this, with idle gaps between beats. It judges the result by the returned data and by a following one-cycle hit. A write hit also merges into the array in its acceptance cycle while the memory write is still waiting for memory, under back-pressure. The bench checks this through the fields memory receives and a later read of the merged word.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MWR  = 2'd1,
    ST_BREQ = 2'd2,
    ST_FILL = 2'd3
  } wtc_state_e;
endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned TAG_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [TAG_W-1:0] set_tag
);
  localparam int unsigned LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= '0;
    else if (set_en) valid_q[set_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (set_en) tag_q[set_idx] <= set_tag;
  end

  assign lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);

  // R8 / R4: a completed refill leaves the line valid under the new tag
  assert_tag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> valid_q[$past(set_idx)] && (tag_q[$past(set_idx)] == $past(set_tag)));
endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store #(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned WSEL_W = 2,
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [WSEL_W-1:0]   wr_wsel,
  input  logic [DATA_W/8-1:0] wr_be,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [IDX_W-1:0]    rd_idx,
  input  logic [WSEL_W-1:0]   rd_wsel,
  output logic [DATA_W-1:0]   rd_data
);
  localparam int unsigned BE_W  = DATA_W / 8;
  localparam int unsigned DEPTH = 1 << (IDX_W + WSEL_W);

  logic [DATA_W-1:0]       arr_q [DEPTH];
  logic [IDX_W+WSEL_W-1:0] wa;

  assign wa      = {wr_idx, wr_wsel};
  assign rd_data = arr_q[{rd_idx, rd_wsel}];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < BE_W; b++) begin
        if (wr_be[b]) arr_q[wa][b*8 +: 8] <= wr_data[b*8 +: 8];
      end
    end
  end

  // R7: each enabled lane lands in the addressed word
  for (genvar g = 0; g < BE_W; g++) begin : g_lane_chk
    assert_lane_merge_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_be[g]) |=> arr_q[$past(wa)][g*8 +: 8] == $past(wr_data[g*8 +: 8]));
  end
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned IDX_W      = 4,
  parameter int unsigned WSEL_W     = 2,
  parameter int unsigned BSEL_W     = 2,
  parameter int unsigned TAG_W      = 24,
  parameter int unsigned LINE_WORDS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_be,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic                mem_req_write,
  output logic [ADDR_W-1:0]   mem_req_addr,
  output logic [DATA_W-1:0]   mem_req_wdata,
  output logic [DATA_W/8-1:0] mem_req_be,
  input  logic                mem_rsp_valid,
  input  logic [DATA_W-1:0]   mem_rsp_data,
  output logic [IDX_W-1:0]    lk_idx,
  output logic [TAG_W-1:0]    lk_tag,
  input  logic                lk_hit,
  output logic                set_en,
  output logic [IDX_W-1:0]    set_idx,
  output logic [TAG_W-1:0]    set_tag,
  output logic                wr_en,
  output logic [IDX_W-1:0]    wr_idx,
  output logic [WSEL_W-1:0]   wr_wsel,
  output logic [DATA_W/8-1:0] wr_be,
  output logic [DATA_W-1:0]   wr_data,
  output logic [IDX_W-1:0]    rd_idx,
  output logic [WSEL_W-1:0]   rd_wsel,
  input  logic [DATA_W-1:0]   rd_data
);
  localparam int unsigned BE_W  = DATA_W / 8;
  localparam int unsigned OFF_W = WSEL_W + BSEL_W;
  localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(LINE_WORDS - 1);

  wtc_state_e          st_q;
  logic [ADDR_W-1:0]   a_q;
  logic [DATA_W-1:0]   wd_q;
  logic [BE_W-1:0]     be_q;
  logic                hit_q;
  logic [WSEL_W-1:0]   beat_q;
  logic                rsp_q;
  logic [DATA_W-1:0]   rdat_q;
  logic                accept;
  logic                beat;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign beat      = (st_q == ST_FILL) && mem_rsp_valid;
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdat_q;

  assign lk_idx  = req_addr[OFF_W +: IDX_W];
  assign lk_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign rd_idx  = req_addr[OFF_W +: IDX_W];
  assign rd_wsel = req_addr[BSEL_W +: WSEL_W];

  assign set_en  = beat && (beat_q == LAST_BEAT);
  assign set_idx = a_q[OFF_W +: IDX_W];
  assign set_tag = a_q[ADDR_W-1 -: TAG_W];

  assign mem_req_valid = (st_q == ST_MWR) || (st_q == ST_BREQ);
  assign mem_req_write = (st_q == ST_MWR);
  assign mem_req_addr  = (st_q == ST_MWR) ? a_q
                                          : {a_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_req_wdata = wd_q;
  assign mem_req_be    = (st_q == ST_MWR) ? be_q : '1;

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = a_q[OFF_W +: IDX_W];
    wr_wsel = beat_q;
    wr_be   = '1;
    wr_data = mem_rsp_data;
    if (beat) begin
      wr_en = 1'b1;
    end else if (accept && req_write && lk_hit) begin
      wr_en   = 1'b1;
      wr_idx  = req_addr[OFF_W +: IDX_W];
      wr_wsel = req_addr[BSEL_W +: WSEL_W];
      wr_be   = req_be;
      wr_data = req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      a_q    <= '0;
      wd_q   <= '0;
      be_q   <= '0;
      hit_q  <= 1'b0;
      beat_q <= '0;
      rsp_q  <= 1'b0;
      rdat_q <= '0;
    end else begin
      rsp_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          a_q   <= req_addr;
          wd_q  <= req_wdata;
          be_q  <= req_be;
          hit_q <= lk_hit;
          if (req_write) begin
            st_q <= ST_MWR;
          end else if (lk_hit) begin
            rsp_q  <= 1'b1;
            rdat_q <= rd_data;
          end else begin
            st_q <= ST_BREQ;
          end
        end
        ST_MWR: if (mem_req_ready) begin
          if (hit_q) begin
            rsp_q <= 1'b1;
            st_q  <= ST_IDLE;
          end else begin
            st_q <= ST_BREQ;
          end
        end
        ST_BREQ: if (mem_req_ready) begin
          beat_q <= '0;
          st_q   <= ST_FILL;
        end
        ST_FILL: if (mem_rsp_valid) begin
          beat_q <= beat_q + 1'b1;
          if (beat_q == a_q[BSEL_W +: WSEL_W]) rdat_q <= mem_rsp_data;
          if (beat_q == LAST_BEAT) begin
            rsp_q <= 1'b1;
            st_q  <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R9: an unaccepted memory request holds still
  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

  // R3: burst reads start on a line boundary
  assert_burst_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_write) |-> (mem_req_addr[OFF_W-1:0] == '0));

  // R5: an accepted read that hits answers on the next cycle
  assert_hit_resp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write && lk_hit) |=> rsp_valid);

  // R9: no new access is taken while memory is being used
  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !rsp_valid || !mem_req_valid);
endmodule

// File: rtl/wt_line_cache.sv
module wt_line_cache #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned LINE_CNT   = 16,
  parameter int unsigned LINE_WORDS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_be,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic                mem_req_write,
  output logic [ADDR_W-1:0]   mem_req_addr,
  output logic [DATA_W-1:0]   mem_req_wdata,
  output logic [DATA_W/8-1:0] mem_req_be,
  input  logic                mem_rsp_valid,
  input  logic [DATA_W-1:0]   mem_rsp_data
);
  localparam int unsigned BE_W   = DATA_W / 8;
  localparam int unsigned BSEL_W = $clog2(BE_W);
  localparam int unsigned WSEL_W = $clog2(LINE_WORDS);
  localparam int unsigned IDX_W  = $clog2(LINE_CNT);
  localparam int unsigned TAG_W  = ADDR_W - IDX_W - WSEL_W - BSEL_W;

  logic [IDX_W-1:0]  lk_idx;
  logic [TAG_W-1:0]  lk_tag;
  logic              lk_hit;
  logic              set_en;
  logic [IDX_W-1:0]  set_idx;
  logic [TAG_W-1:0]  set_tag;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [WSEL_W-1:0] wr_wsel;
  logic [BE_W-1:0]   wr_be;
  logic [DATA_W-1:0] wr_data;
  logic [IDX_W-1:0]  rd_idx;
  logic [WSEL_W-1:0] rd_wsel;
  logic [DATA_W-1:0] rd_data;

  wtc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_hit(lk_hit),
    .set_en(set_en), .set_idx(set_idx), .set_tag(set_tag)
  );

  wtc_data_store #(.IDX_W(IDX_W), .WSEL_W(WSEL_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_wsel(wr_wsel), .wr_be(wr_be), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_wsel(rd_wsel), .rd_data(rd_data)
  );

  wtc_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .WSEL_W(WSEL_W),
    .BSEL_W(BSEL_W), .TAG_W(TAG_W), .LINE_WORDS(LINE_WORDS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_req_be(mem_req_be),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_hit(lk_hit),
    .set_en(set_en), .set_idx(set_idx), .set_tag(set_tag),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_wsel(wr_wsel), .wr_be(wr_be), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_wsel(rd_wsel), .rd_data(rd_data)
  );
endmodule

// File: tb/wt_line_cache_tb.sv
module wt_line_cache_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [31:0] req_addr, req_wdata;
  logic [3:0]  req_be;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        mem_req_valid, mem_req_ready, mem_req_write;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic [3:0]  mem_req_be;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  wt_line_cache u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_req_be(mem_req_be),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  // memory model state
  logic [31:0] img [1024];
  int          mem_delay = 0;
  bit          gap_mode  = 1'b0;
  int          spur_left = 0;
  int          n_wr = 0, n_burst = 0, stab_err = 0;
  logic [31:0] last_wr_addr, last_wr_data, last_burst_addr;
  logic [3:0]  last_wr_be;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    int beats_left = 0, wait_n = 0;
    bit waiting = 1'b0, gap_tog = 1'b0;
    logic [31:0] hold_addr = '0;
    logic [9:0]  base = '0;
    for (int i = 0; i < 1024; i++) img[i] = (i * 32'h0103_0507) ^ 32'h5A5A_0000;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
      if (beats_left > 0) begin
        if (gap_mode && gap_tog) gap_tog = 1'b0;
        else begin
          gap_tog = 1'b1;
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = img[base + 10'(4 - beats_left)];
          beats_left--;
        end
      end else if (spur_left > 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = 32'hDEAD_0000 + 32'(spur_left);
        spur_left--;
      end else if (mem_req_valid) begin
        if (!waiting) begin
          waiting = 1'b1; wait_n = 0; hold_addr = mem_req_addr;
        end else if (mem_req_addr != hold_addr) stab_err++;
        if (wait_n >= mem_delay) begin
          mem_req_ready = 1'b1;
          waiting = 1'b0;
          if (mem_req_write) begin
            for (int b = 0; b < 4; b++)
              if (mem_req_be[b]) img[mem_req_addr[11:2]][b*8 +: 8] = mem_req_wdata[b*8 +: 8];
            n_wr++;
            last_wr_addr = mem_req_addr; last_wr_data = mem_req_wdata; last_wr_be = mem_req_be;
          end else begin
            beats_left = 4; gap_tog = 1'b0;
            base = {mem_req_addr[11:4], 2'b00};
            n_burst++;
            last_burst_addr = mem_req_addr;
          end
        end else wait_n++;
      end
    end
  end

  task automatic do_req(input logic wr, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] be, output logic [31:0] rd, output int lat,
                        output bit stall_ok);
    int g = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready && g < 200) begin @(negedge clk); g++; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1; stall_ok = 1'b1;
    while (!rsp_valid && lat < 300) begin
      if (req_ready) stall_ok = 1'b0;
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
    if (!rsp_valid) chk(1'b0, "R9", "no response", 32'(lat), 32'd0);
  endtask

  task automatic t_reset;
    chk(req_ready === 1'b1, "R1", "ready after reset", 32'(req_ready), 32'd1);
    chk(rsp_valid === 1'b0, "R1", "rsp idle after reset", 32'(rsp_valid), 32'd0);
    chk(mem_req_valid === 1'b0, "R1", "mem idle after reset", 32'(mem_req_valid), 32'd0);
  endtask

  task automatic t_read_miss;
    logic [31:0] rd, exp; int lat; bit st; int b0;
    b0 = n_burst; exp = img[32'h124 >> 2];
    do_req(1'b0, 32'h124, '0, 4'h0, rd, lat, st);
    chk(n_burst == b0 + 1, "R1", "cold read bursts", 32'(n_burst - b0), 32'd1);
    chk(last_burst_addr == 32'h120, "R3", "burst aligned", last_burst_addr, 32'h120);
    chk(rd == exp, "R4", "miss data", rd, exp);
    chk(st, "R9", "stalled during miss", 32'(st), 32'd1);
  endtask

  task automatic t_read_hit;
    logic [31:0] rd; int lat; bit st; int b0;
    b0 = n_burst;
    for (int w = 0; w < 4; w++) begin
      do_req(1'b0, 32'h120 + 32'(w*4), '0, 4'h0, rd, lat, st);
      chk(rd == img[(32'h120 >> 2) + w], "R4", "line word after fill", rd, img[(32'h120 >> 2) + w]);
      chk(lat == 1, "R5", "hit latency", 32'(lat), 32'd1);
    end
    chk(n_burst == b0, "R5", "hit no memory", 32'(n_burst - b0), 32'd0);
  endtask

  task automatic t_last_word;
    logic [31:0] rd, exp; int lat; bit st;
    gap_mode = 1'b1;
    exp = img[32'h33C >> 2];
    do_req(1'b0, 32'h33C, '0, 4'h0, rd, lat, st);
    chk(rd == exp, "R4", "last-beat word", rd, exp);
    chk(lat > 8, "R3", "gapped burst takes beats", 32'(lat), 32'd9);
    do_req(1'b0, 32'h330, '0, 4'h0, rd, lat, st);
    chk(lat == 1 && rd == img[32'h330 >> 2], "R4", "word0 after gapped fill", rd, img[32'h330 >> 2]);
    gap_mode = 1'b0;
  endtask

  task automatic t_write_hit;
    logic [31:0] rd, old, exp; int lat; bit st; int w0;
    w0 = n_wr; old = img[32'h124 >> 2];
    mem_delay = 2;
    do_req(1'b1, 32'h124, 32'h1122_3344, 4'b0101, rd, lat, st);
    mem_delay = 0;
    chk(n_wr == w0 + 1, "R6", "one memory write", 32'(n_wr - w0), 32'd1);
    chk(last_wr_addr == 32'h124, "R6", "write addr", last_wr_addr, 32'h124);
    chk(last_wr_data == 32'h1122_3344, "R6", "write data", last_wr_data, 32'h1122_3344);
    chk(last_wr_be == 4'b0101, "R6", "write be", 32'(last_wr_be), 32'h5);
    exp = (old & 32'hFF00_FF00) | (32'h1122_3344 & 32'h00FF_00FF);
    do_req(1'b0, 32'h124, '0, 4'h0, rd, lat, st);
    chk(rd == exp, "R7", "merged word", rd, exp);
    chk(lat == 1, "R7", "still a hit", 32'(lat), 32'd1);
  endtask

  task automatic t_write_miss;
    logic [31:0] rd; int lat; bit st; int w0, b0;
    w0 = n_wr; b0 = n_burst;
    do_req(1'b1, 32'h548, 32'hCAFE_F00D, 4'hF, rd, lat, st);
    chk(n_wr == w0 + 1 && n_burst == b0 + 1, "R8", "write then refill",
        32'(n_burst - b0), 32'd1);
    do_req(1'b0, 32'h548, '0, 4'h0, rd, lat, st);
    chk(rd == 32'hCAFE_F00D && lat == 1, "R8", "written word cached", rd, 32'hCAFE_F00D);
    do_req(1'b0, 32'h544, '0, 4'h0, rd, lat, st);
    chk(rd == img[32'h544 >> 2] && lat == 1, "R8", "neighbour cached", rd, img[32'h544 >> 2]);
  endtask

  task automatic t_collision;
    logic [31:0] rd; int lat; bit st; int b0;
    b0 = n_burst;
    do_req(1'b0, 32'h224, '0, 4'h0, rd, lat, st);
    chk(rd == img[32'h224 >> 2], "R2", "other tag data", rd, img[32'h224 >> 2]);
    do_req(1'b0, 32'h124, '0, 4'h0, rd, lat, st);
    chk(n_burst == b0 + 2, "R11", "evicted both miss", 32'(n_burst - b0), 32'd2);
    chk(rd == img[32'h124 >> 2], "R11", "refetched data", rd, img[32'h124 >> 2]);
  endtask

  task automatic t_spurious;
    logic [31:0] rd; int lat; bit st; bit seen = 1'b0;
    spur_left = 3;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (rsp_valid) seen = 1'b1;
    end
    chk(!seen, "R10", "no response from stray beats", 32'(seen), 32'd0);
    do_req(1'b0, 32'h128, '0, 4'h0, rd, lat, st);
    chk(rd == img[32'h128 >> 2] && lat == 1, "R10", "cache untouched", rd, img[32'h128 >> 2]);
  endtask

  task automatic t_backpressure;
    logic [31:0] rd, exp; int lat; bit st;
    mem_delay = 3; gap_mode = 1'b1;
    exp = img[32'h6A8 >> 2];
    do_req(1'b0, 32'h6A8, '0, 4'h0, rd, lat, st);
    mem_delay = 0; gap_mode = 1'b0;
    chk(stab_err == 0, "R9", "request held stable", 32'(stab_err), 32'd0);
    chk(st, "R9", "stalled under back-pressure", 32'(st), 32'd1);
    chk(rd == exp, "R3", "data under back-pressure", rd, exp);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_be = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_miss();
    t_read_hit();
    t_last_word();
    t_write_hit();
    t_write_miss();
    t_collision();
    t_spurious();
    t_backpressure();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "R9", "watchdog expired", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule